// File: doc/BRIEF.md
# GPIO Controller with Pin Interrupts

This block is a register-mapped general-purpose I/O controller with up to four ports of up to 32 pins each. Software drives every port through an output-value register and an output-enable register, and reads the pad state back through a read-only input register per port. The pad cells themselves sit outside; the block exports only output and output-enable vectors and takes in the raw pad vector. Every pad input passes through a two-flop synchroniser.

The first port also carries per-pin interrupt logic. Each pin has an enable bit, a mask bit, a sensing-type bit (edge or level) and a polarity bit. Edge events are latched until software clears them through a write-one-to-clear register. Level events follow the pin and are never latched. An optional debounce filter, timed by a slow internal tick, can be switched in per pin. A single interrupt line carries the OR of all visible status bits.

The bus is a simple APB-style interface. A write takes effect at the access-phase clock edge, and read data is registered at the setup-phase edge. Offsets that the map does not define read as zero.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset every register reads zero, the output and output-enable vectors are zero, and the interrupt line is low.
- R2: Port p has its output-value register at offset 0x00 + 0x0C*p and its output-enable register at 0x04 + 0x0C*p. Both read back, and they drive bits [p*PORT_W +: PORT_W] of the output and output-enable vectors from the cycle after the write.
- R3: The input register of port p sits at 0x50 + 4*p and returns the pad value after a two-flop synchroniser. A read whose setup phase begins one cycle after a pad change still returns the old value.
- R4: Reads of undefined offsets (for example 0x2C or 0x44) return zero. Writes to them change no register and no output.
- R5: A pin whose type bit (offset 0x38) is 1 is edge-sensitive. With polarity (0x3C) set to 1 a rising edge is latched; with polarity 0 a falling edge is latched. The latched event is visible in status (0x40) and persists after the pin returns.
- R6: A pin whose type bit is 0 is level-sensitive. Its status bit is set while the pin equals its polarity bit, clears when the pin changes, and ignores end-of-interrupt writes.
- R7: A mask bit of 1 (offset 0x34) hides that pin's status bit and keeps it off the interrupt line. A latched edge survives masking and reappears on unmask.
- R8: Writing ones to the end-of-interrupt register (0x4C) clears those latched edges, and zero bits leave their latches alone. An edge that arrives in the same cycle as the clear stays pending.
- R9: The interrupt line is the registered OR of all status bits and follows status one cycle later.
- R10: With its debounce bit (0x48) set, a pin's interrupt source changes only after the pin has differed from it for DB_LEN consecutive slow ticks. Shorter glitches raise no interrupt.
- R11: Each pin detects only the edge its polarity selects. The opposite edge latches nothing.
- R12: A pin whose enable bit (0x30) is 0 neither latches an edge nor shows a level status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Bus write strobe |
| paddr | input | ADDR_W | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Registered read data |
| pad_in | input | NUM_PORTS*PORT_W | Raw pad inputs |
| pad_out | output | NUM_PORTS*PORT_W | Output values |
| pad_oe | output | NUM_PORTS*PORT_W | Output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The two functions that can meet in one cycle are an edge being latched and an end-of-interrupt clear for the same register. The bench raises one pin so that its synchronised rising edge reaches the latch exactly at the access-phase edge of an end-of-interrupt write. The same write also covers a second pin that was already pending. The result is correct when status shows the older pin cleared and the newly arrived pin still pending.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  // Port register stride and interrupt-block offsets (byte addresses)
  localparam int unsigned PORT_STRIDE = 'h0C;
  localparam int unsigned OFS_DIR     = 'h04;
  localparam int unsigned OFS_IEN     = 'h30;
  localparam int unsigned OFS_IMSK    = 'h34;
  localparam int unsigned OFS_ITYP    = 'h38;
  localparam int unsigned OFS_IPOL    = 'h3C;
  localparam int unsigned OFS_ISTAT   = 'h40;
  localparam int unsigned OFS_DBEN    = 'h48;
  localparam int unsigned OFS_EOI     = 'h4C;
  localparam int unsigned OFS_EXT     = 'h50;
  localparam int unsigned EXT_STRIDE  = 'h04;
  localparam int unsigned BUS_W       = 32;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
  parameter int W        = 32,
  parameter int TICK_DIV = 1000,
  parameter int DB_LEN   = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int CW = (DB_LEN > 1) ? $clog2(DB_LEN) : 1;

  logic [TW-1:0] tcnt;
  logic          tick;

  assign tick = (tcnt == TW'(TICK_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || tick) tcnt <= '0;
    else             tcnt <= tcnt + 1'b1;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic [CW-1:0] run;
    always_ff @(posedge clk) begin
      if (rst) begin
        run     <= '0;
        dout[i] <= 1'b0;
      end else if (din[i] == dout[i]) begin
        run <= '0;
      end else if (tick) begin
        if (run == CW'(DB_LEN - 1)) begin
          dout[i] <= din[i];
          run     <= '0;
        end else begin
          run <= run + 1'b1;
        end
      end
    end
  end

  // R10: the filtered value moves only on a slow tick
  p_filter_on_tick_r10: assert property (@(posedge clk) disable iff (rst)
    (dout != $past(dout)) |-> $past(tick));
endmodule

// File: rtl/gpio_irq_core.sv
module gpio_irq_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] src,
  input  logic [W-1:0] en,
  input  logic [W-1:0] edge_sel,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] mask,
  input  logic         eoi_we,
  input  logic [W-1:0] eoi_bits,
  output logic [W-1:0] status,
  output logic         irq
);
  logic [W-1:0] prev, latch_q, ev_hit, lvl, clr;

  assign ev_hit = en & edge_sel & ((pol & src & ~prev) | (~pol & ~src & prev));
  assign clr    = eoi_we ? eoi_bits : '0;
  assign lvl    = en & ~edge_sel & ~(src ^ pol);
  assign status = ((latch_q & edge_sel) | lvl) & ~mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev    <= '0;
      latch_q <= '0;
      irq     <= 1'b0;
    end else begin
      prev    <= src;
      latch_q <= (latch_q & en & edge_sel & ~clr) | ev_hit;
      irq     <= |status;
    end
  end

  p_irq_follows_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(|status)));
  p_no_latch_disabled_r12: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((latch_q & ~$past(en)) == '0));
  p_eoi_clears_r8: assert property (@(posedge clk) disable iff (rst)
    eoi_we |=> ((latch_q & $past(eoi_bits) & ~$past(ev_hit)) == '0));
  p_level_unlatched_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((latch_q & ~$past(edge_sel)) == '0));
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int TICK_DIV  = 1000,
  parameter int DB_LEN    = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          psel,
  input  logic                          penable,
  input  logic                          pwrite,
  input  logic [ADDR_W-1:0]             paddr,
  input  logic [31:0]                   pwdata,
  output logic [31:0]                   prdata,
  input  logic [NUM_PORTS*PORT_W-1:0]   pad_in,
  output logic [NUM_PORTS*PORT_W-1:0]   pad_out,
  output logic [NUM_PORTS*PORT_W-1:0]   pad_oe,
  output logic                          irq
);
  localparam int PW = NUM_PORTS * PORT_W;

  logic wr, rd_setup, eoi_we;
  logic [PORT_W-1:0] dout_r [NUM_PORTS];
  logic [PORT_W-1:0] dir_r  [NUM_PORTS];
  logic [PORT_W-1:0] ien, imsk, ityp, ipol, dben;
  logic [PORT_W-1:0] pad_db, src, status;
  logic [PW-1:0]     pad_s;
  logic [BUS_W-1:0]  rdv;

  function automatic logic at(input logic [ADDR_W-1:0] a, input int unsigned ofs);
    return a == ADDR_W'(ofs);
  endfunction

  assign wr       = psel & penable & pwrite;
  assign rd_setup = psel & ~penable;
  assign eoi_we   = wr & at(paddr, OFS_EOI);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        dout_r[p] <= '0;
        dir_r[p]  <= '0;
      end
      ien  <= '0;
      imsk <= '0;
      ityp <= '0;
      ipol <= '0;
      dben <= '0;
    end else if (wr) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (at(paddr, p * PORT_STRIDE))           dout_r[p] <= pwdata[PORT_W-1:0];
        if (at(paddr, p * PORT_STRIDE + OFS_DIR)) dir_r[p]  <= pwdata[PORT_W-1:0];
      end
      if (at(paddr, OFS_IEN))  ien  <= pwdata[PORT_W-1:0];
      if (at(paddr, OFS_IMSK)) imsk <= pwdata[PORT_W-1:0];
      if (at(paddr, OFS_ITYP)) ityp <= pwdata[PORT_W-1:0];
      if (at(paddr, OFS_IPOL)) ipol <= pwdata[PORT_W-1:0];
      if (at(paddr, OFS_DBEN)) dben <= pwdata[PORT_W-1:0];
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign pad_out[p*PORT_W +: PORT_W] = dout_r[p];
    assign pad_oe[p*PORT_W +: PORT_W]  = dir_r[p];
  end

  gpio_sync #(.W(PW)) u_sync (
    .clk (clk), .rst (rst), .d (pad_in), .q (pad_s)
  );

  gpio_debounce #(.W(PORT_W), .TICK_DIV(TICK_DIV), .DB_LEN(DB_LEN)) u_db (
    .clk (clk), .rst (rst), .din (pad_s[PORT_W-1:0]), .dout (pad_db)
  );

  assign src = (dben & pad_db) | (~dben & pad_s[PORT_W-1:0]);

  gpio_irq_core #(.W(PORT_W)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .src      (src),
    .en       (ien),
    .edge_sel (ityp),
    .pol      (ipol),
    .mask     (imsk),
    .eoi_we   (eoi_we),
    .eoi_bits (pwdata[PORT_W-1:0]),
    .status   (status),
    .irq      (irq)
  );

  always_comb begin
    rdv = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (at(paddr, p * PORT_STRIDE))           rdv = BUS_W'(dout_r[p]);
      if (at(paddr, p * PORT_STRIDE + OFS_DIR)) rdv = BUS_W'(dir_r[p]);
      if (at(paddr, OFS_EXT + p * EXT_STRIDE))  rdv = BUS_W'(pad_s[p*PORT_W +: PORT_W]);
    end
    if (at(paddr, OFS_IEN))   rdv = BUS_W'(ien);
    if (at(paddr, OFS_IMSK))  rdv = BUS_W'(imsk);
    if (at(paddr, OFS_ITYP))  rdv = BUS_W'(ityp);
    if (at(paddr, OFS_IPOL))  rdv = BUS_W'(ipol);
    if (at(paddr, OFS_ISTAT)) rdv = BUS_W'(status);
    if (at(paddr, OFS_DBEN))  rdv = BUS_W'(dben);
  end

  always_ff @(posedge clk) begin
    if (rst)           prdata <= '0;
    else if (rd_setup) prdata <= rdv;
  end

  p_dir_write_r2: assert property (@(posedge clk) disable iff (rst)
    (wr && at(paddr, OFS_DIR)) |=> (pad_oe[PORT_W-1:0] == $past(pwdata[PORT_W-1:0])));
  p_undef_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_setup && at(paddr, 'h44)) |=> (prdata == '0));
endmodule

// File: tb/gpio_bank_ctrl_test.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_test;
  localparam int NP = 4;
  localparam int W  = 8;

  logic clk = 1'b0;
  logic rst;
  logic psel, penable, pwrite;
  logic [7:0]  paddr;
  logic [31:0] pwdata, prdata;
  logic [NP*W-1:0] pad_in, pad_out, pad_oe;
  logic irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_bank_ctrl #(.NUM_PORTS(NP), .PORT_W(W), .ADDR_W(8), .TICK_DIV(4), .DB_LEN(3)) uut (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; penable = 0; paddr = a;
    @(negedge clk); penable = 1; d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    bus_rd(8'h00, v); check("R1 data reg", v, 0);
    bus_rd(8'h04, v); check("R1 dir reg", v, 0);
    bus_rd(8'h30, v); check("R1 enable reg", v, 0);
    bus_rd(8'h40, v); check("R1 status", v, 0);
    check("R1 outputs", pad_out | pad_oe, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_ports;
    logic [31:0] v;
    for (int p = 0; p < NP; p++) begin
      bus_wr(8'(p * 12), 32'(8'hA0 + p));
      bus_wr(8'(p * 12 + 4), 32'(8'h50 + p));
    end
    for (int p = 0; p < NP; p++) begin
      bus_rd(8'(p * 12), v);     check("R2 data readback", v, 32'(8'hA0 + p));
      bus_rd(8'(p * 12 + 4), v); check("R2 dir readback", v, 32'(8'h50 + p));
      check("R2 out slice", 32'(pad_out[p*W +: W]), 32'(8'hA0 + p));
      check("R2 oe slice", 32'(pad_oe[p*W +: W]), 32'(8'h50 + p));
    end
  endtask

  task automatic t_ext;
    logic [31:0] v;
    @(negedge clk); pad_in = 32'h44332211;
    bus_rd(8'h50, v); check("R3 sync depth old value", v, 0);
    for (int p = 0; p < NP; p++) begin
      bus_rd(8'(8'h50 + 4 * p), v);
      check("R3 ext port", v, 32'((p + 1) * 8'h11));
    end
    @(negedge clk); pad_in = '0;
    wait_clk(3);
  endtask

  task automatic t_undef;
    logic [31:0] v;
    logic [NP*W-1:0] o, e;
    o = pad_out; e = pad_oe;
    bus_wr(8'h2C, 32'hFFFF_FFFF);
    bus_wr(8'h44, 32'hFFFF_FFFF);
    bus_rd(8'h2C, v); check("R4 undef 0x2C", v, 0);
    bus_rd(8'h44, v); check("R4 undef 0x44", v, 0);
    check("R4 outputs untouched", 32'(pad_out ^ o) | 32'(pad_oe ^ e), 0);
    bus_rd(8'h30, v); check("R4 enable untouched", v, 0);
  endtask

  task automatic t_edge;
    logic [31:0] v;
    bus_wr(8'h38, 32'h03); bus_wr(8'h3C, 32'h01); bus_wr(8'h30, 32'h03);
    @(negedge clk); pad_in[0] = 1; wait_clk(5);
    bus_rd(8'h40, v); check("R5 rising latched", v, 32'h01);
    check("R9 irq high", irq, 1);
    @(negedge clk); pad_in[1] = 1; wait_clk(5);
    bus_rd(8'h40, v); check("R11 rise ignored on falling pin", v, 32'h01);
    @(negedge clk); pad_in[1] = 0; wait_clk(5);
    bus_rd(8'h40, v); check("R5 falling latched", v, 32'h03);
    @(negedge clk); pad_in[0] = 0; wait_clk(5);
    bus_rd(8'h40, v); check("R5 latch persists", v, 32'h03);
    bus_wr(8'h4C, 32'h00);
    bus_rd(8'h40, v); check("R8 zero bits keep", v, 32'h03);
    bus_wr(8'h4C, 32'h01);
    bus_rd(8'h40, v); check("R8 clear bit0", v, 32'h02);
    bus_wr(8'h4C, 32'h02);
    bus_rd(8'h40, v); check("R8 clear bit1", v, 32'h00);
    check("R9 irq low", irq, 0);
  endtask

  task automatic t_mask;
    logic [31:0] v;
    @(negedge clk); pad_in[0] = 1; wait_clk(5);
    bus_wr(8'h34, 32'h01);
    bus_rd(8'h40, v); check("R7 masked status", v, 0);
    check("R7 masked irq", irq, 0);
    bus_wr(8'h34, 32'h00);
    bus_rd(8'h40, v); check("R7 unmask shows latch", v, 32'h01);
    check("R7 irq back", irq, 1);
    @(negedge clk); pad_in[0] = 0; wait_clk(5);
    bus_wr(8'h4C, 32'hFF);
    bus_wr(8'h30, 32'h00);
  endtask

  task automatic t_level;
    logic [31:0] v;
    bus_wr(8'h38, 32'h00); bus_wr(8'h3C, 32'h04); bus_wr(8'h30, 32'h0C);
    bus_rd(8'h40, v); check("R6 active-low level", v, 32'h08);
    @(negedge clk); pad_in[2] = 1; wait_clk(5);
    bus_rd(8'h40, v); check("R6 active-high level", v, 32'h0C);
    bus_wr(8'h4C, 32'hFF);
    bus_rd(8'h40, v); check("R6 eoi no effect", v, 32'h0C);
    @(negedge clk); pad_in[3] = 1; pad_in[2] = 0; wait_clk(5);
    bus_rd(8'h40, v); check("R6 level follows pin", v, 32'h00);
    bus_wr(8'h30, 32'h00);
    @(negedge clk); pad_in[3] = 0; wait_clk(3);
  endtask

  task automatic t_enable;
    logic [31:0] v;
    bus_wr(8'h38, 32'h10); bus_wr(8'h3C, 32'h10);
    @(negedge clk); pad_in[4] = 1; wait_clk(5);
    bus_rd(8'h40, v); check("R12 disabled no status", v, 0);
    bus_wr(8'h30, 32'h10);
    bus_rd(8'h40, v); check("R12 no stale latch", v, 0);
    check("R12 irq low", irq, 0);
    bus_wr(8'h30, 32'h00);
    @(negedge clk); pad_in[4] = 0; wait_clk(3);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    bus_wr(8'h38, 32'h03); bus_wr(8'h3C, 32'h03); bus_wr(8'h30, 32'h03);
    @(negedge clk); pad_in[0] = 1; wait_clk(5);
    @(negedge clk); pad_in[1] = 1;
    bus_wr(8'h4C, 32'h03);
    bus_rd(8'h40, v); check("R8 same-cycle edge survives clear", v, 32'h02);
    bus_wr(8'h4C, 32'h02);
    bus_wr(8'h30, 32'h00);
    @(negedge clk); pad_in[1:0] = 2'b00; wait_clk(3);
  endtask

  task automatic t_debounce;
    logic [31:0] v;
    bus_wr(8'h48, 32'h20); bus_wr(8'h38, 32'h20);
    bus_wr(8'h3C, 32'h20); bus_wr(8'h30, 32'h20);
    @(negedge clk); pad_in[5] = 1; wait_clk(2);
    pad_in[5] = 0; wait_clk(40);
    bus_rd(8'h40, v); check("R10 glitch filtered", v, 0);
    @(negedge clk); pad_in[5] = 1; wait_clk(40);
    bus_rd(8'h40, v); check("R10 stable pulse passes", v, 32'h20);
  endtask

  initial begin
    rst = 1; psel = 0; penable = 0; pwrite = 0; paddr = 0; pwdata = 0; pad_in = '0;
    repeat (4) @(negedge clk);
    rst = 0;
    t_reset();
    t_ports();
    t_ext();
    t_undef();
    t_edge();
    t_mask();
    t_level();
    t_enable();
    t_collide();
    t_debounce();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule